// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

A synthesizable model of a NOR-style parallel flash part. It sits on a simple synchronous bus made of chip select, write enable, byte address, write data and read data. Bus writes are not stored directly. They are decoded as commands by a multi-cycle state machine. The current command mode then decides whether a bus read returns array contents, the status register or a byte from a fixed identification table.

The storage is a small on-chip array split into equal sectors. The device supports the following operations: single-word program, sector erase with confirm, buffered write with a word count, status read and status clear, and lock/unlock sequences that are accepted without effect. Every operation completes in the cycle it is confirmed. Nothing models real program or erase time.

The access width is a parameter of 1, 2 or 4 bytes. Byte address `a` maps to byte lane `a mod W` of word `a / W`, so a multi-byte word is assembled little-endian from consecutive bytes. Array accesses ignore the low address bits below the word size.

Top module: `pflash_cmd_top`

## Requirements
- R1: After reset the whole array reads as all ones, the status register is 0x00 and the device is in read-array mode.
- R2: A write of 0xFF in any command position sends the device to read-array mode. Command positions are the first cycle, the second cycle of erase and lock, and the buffered-write confirm. Query and status modes are left the same way.
- R3: A first-cycle 0x40 or 0x10 arms programming. The next write stores its whole data word at that write's word address, sets status bit 7 and returns to read-array mode.
- R4: 0x20 followed by 0xD0 fills every word of the sector holding the confirm address with all ones, sets status bit 7 and leaves the device in status-read mode. Other sectors are untouched.
- R5: After 0x20, a second cycle of 0xFF or of any value other than 0xD0 erases nothing and returns to read-array mode.
- R6: 0xE8 sets status bit 7. The next write gives an 8-bit word count N, taken from data bits 7:0, and latches the word address of that write as the start. The next N writes are data and are stored at consecutive word addresses from the start, whatever their bus address, with 0xFF treated as data. A confirm of 0xD0 then sets status bit 7 and leaves status-read mode.
- R7: A buffered-write confirm other than 0xD0 returns to read-array mode, and the data words already stored stay in the array.
- R8: 0x70 selects status-read mode. 0x50 clears the status register to 0x00. While the active command is 0x20, 0x50, 0x60, 0x70 or 0xE8, reads return the status byte in bits 7:0 with the upper bits zero.
- R9: After 0x98, a read returns in bits 7:0 the identification byte indexed by address bits 7:0, with zero above. Index 0x10..0x12 holds 0x51, 0x52, 0x59 and 0x13 holds 0x01. 0x15 holds 0x31, 0x27 holds log2 of the array size in bytes, 0x2D holds the sector count minus one and 0x31 holds 0x50. Every index above 0x3C reads 0.
- R10: 0x60 followed by 0x01 or 0xD0 sets status bit 7 and leaves status-read mode with no protection effect. A second cycle of any other value returns to read-array mode.
- R11: A first-cycle value that is not a known command returns the device to read-array mode.
- R12: Array reads and program writes use the word containing the byte address and ignore the low address bits.
- R13: Read data appears on `rdata` one clock after the read cycle and holds its value through cycles that are not reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; a bus cycle happens when high |
| we | input | 1 | 1 = write (command/data), 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8*WIDTH_BYTES | Write data; commands use bits 7:0 |
| rdata | output | 8*WIDTH_BYTES | Registered read data |

## Verification
Every write takes effect at the clock edge on which it is presented. A read is registered, so its result is on `rdata` one edge after the read cycle. The scoreboard records an expected word for each read as the read is driven. The monitor notes at each rising edge whether a read was on the bus, and compares at the following falling edge, when `rdata` has settled. Hold behaviour is checked at falling edges several idle cycles after a read.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   localparam logic [7:0] OP_READ    = 8'hFF;
   localparam logic [7:0] OP_PROG_A  = 8'h40;
   localparam logic [7:0] OP_PROG_B  = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_BUFFER  = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_LOCKSET = 8'h01;

   localparam logic [7:0] QUERY_LAST = 8'h3C;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ARG  = 2'd1,
      PH_DATA = 2'd2,
      PH_CONF = 2'd3
   } phase_e;

   function automatic logic shows_status(input logic [7:0] op);
      return (op == OP_ERASE) || (op == OP_CLEAR) || (op == OP_LOCK) ||
             (op == OP_STATUS) || (op == OP_BUFFER);
   endfunction

endpackage

// File: rtl/pflash_query_rom.sv
module pflash_query_rom #(
   parameter int SECTOR_BYTES = 64,
   parameter int NUM_SECTORS  = 4
) (
   input  logic [7:0] idx,
   output logic [7:0] qbyte
);
   import pflash_pkg::*;

   localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS;
   localparam logic [7:0] SIZE_LOG = 8'($clog2(TOTAL_BYTES));
   localparam logic [7:0] NSEC_LO  = 8'((NUM_SECTORS - 1) & 255);
   localparam logic [7:0] NSEC_HI  = 8'(((NUM_SECTORS - 1) >> 8) & 255);
   localparam logic [7:0] SEC_MID  = 8'((SECTOR_BYTES >> 8) & 255);
   localparam logic [7:0] SEC_HI   = 8'((SECTOR_BYTES >> 16) & 255);

   always_comb begin
      qbyte = 8'h00;
      if (idx <= QUERY_LAST) begin
         case (idx)
            8'h10: qbyte = 8'h51;
            8'h11: qbyte = 8'h52;
            8'h12: qbyte = 8'h59;
            8'h13: qbyte = 8'h01;
            8'h15: qbyte = 8'h31;
            8'h1B: qbyte = 8'h45;
            8'h1C: qbyte = 8'h55;
            8'h1F: qbyte = 8'h07;
            8'h20: qbyte = 8'h07;
            8'h21: qbyte = 8'h0A;
            8'h23: qbyte = 8'h04;
            8'h24: qbyte = 8'h04;
            8'h25: qbyte = 8'h04;
            8'h27: qbyte = SIZE_LOG;
            8'h28: qbyte = 8'h02;
            8'h2A: qbyte = 8'h0B;
            8'h2C: qbyte = 8'h01;
            8'h2D: qbyte = NSEC_LO;
            8'h2E: qbyte = NSEC_HI;
            8'h2F: qbyte = SEC_MID;
            8'h30: qbyte = SEC_HI;
            8'h31: qbyte = 8'h50;
            8'h32: qbyte = 8'h52;
            8'h33: qbyte = 8'h49;
            8'h34: qbyte = 8'h31;
            8'h35: qbyte = 8'h31;
            default: qbyte = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
   parameter int DW      = 16,
   parameter int WORDS   = 128,
   parameter int WORD_W  = 7,
   parameter int SECW_W  = 5,
   parameter int SEC_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_idx,
   input  logic [DW-1:0]     wr_data,
   input  logic              erase_en,
   input  logic [SEC_W-1:0]  erase_sec,
   input  logic [WORD_W-1:0] rd_idx,
   output logic [DW-1:0]     rd_data
);

   logic [DW-1:0] words [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      localparam logic [WORD_W-1:0] WI = WORD_W'(g);
      logic [DW-1:0] word_q;
      logic          wipe;
      logic          load;

      assign wipe = erase_en && (WI[WORD_W-1:SECW_W] == erase_sec);
      assign load = wr_en && (wr_idx == WI);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (wipe) begin
            word_q <= '1;
         end else if (load) begin
            word_q <= wr_data;
         end
      end

      assign words[g] = word_q;
   end

   assign rd_data = words[rd_idx];

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
   import pflash_pkg::*;
#(
   parameter int DW     = 16,
   parameter int WORD_W = 7,
   parameter int WSTEP  = 1,
   parameter int SECW_W = 5,
   parameter int SEC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] word_idx,
   input  logic [DW-1:0]     wdata,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_idx,
   output logic              erase_en,
   output logic [SEC_W-1:0]  erase_sec,
   output logic [7:0]        cmd_q,
   output phase_e            phase_q,
   output logic [7:0]        status_q
);

   logic [7:0]        op;
   logic [7:0]        cmd_d;
   phase_e            phase_d;
   logic [7:0]        status_d;
   logic [7:0]        cnt_q, cnt_d;
   logic [WORD_W-1:0] ptr_q, ptr_d;

   assign op        = wdata[7:0];
   assign erase_sec = word_idx[WORD_W-1:SECW_W];

   always_comb begin
      cmd_d    = cmd_q;
      phase_d  = phase_q;
      status_d = status_q;
      cnt_d    = cnt_q;
      ptr_d    = ptr_q;
      wr_en    = 1'b0;
      wr_idx   = word_idx;
      erase_en = 1'b0;
      if (bus_wr) begin
         unique case (phase_q)
            PH_CMD: begin
               case (op)
                  OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK: begin
                     cmd_d   = op;
                     phase_d = PH_ARG;
                  end
                  OP_BUFFER: begin
                     cmd_d       = op;
                     phase_d     = PH_ARG;
                     status_d[7] = 1'b1;
                  end
                  OP_CLEAR: begin
                     cmd_d    = op;
                     status_d = 8'h00;
                  end
                  OP_STATUS, OP_QUERY: cmd_d = op;
                  default: cmd_d = OP_READ;
               endcase
            end
            PH_ARG: begin
               phase_d = PH_CMD;
               case (cmd_q)
                  OP_PROG_A, OP_PROG_B: begin
                     wr_en       = 1'b1;
                     status_d[7] = 1'b1;
                     cmd_d       = OP_READ;
                  end
                  OP_ERASE: begin
                     if (op == OP_CONFIRM) begin
                        erase_en    = 1'b1;
                        status_d[7] = 1'b1;
                     end else begin
                        cmd_d = OP_READ;
                     end
                  end
                  OP_LOCK: begin
                     if (op == OP_LOCKSET || op == OP_CONFIRM) begin
                        status_d[7] = 1'b1;
                     end else begin
                        cmd_d = OP_READ;
                     end
                  end
                  OP_BUFFER: begin
                     cnt_d   = op;
                     ptr_d   = word_idx;
                     phase_d = (op == 8'h00) ? PH_CONF : PH_DATA;
                  end
                  default: cmd_d = OP_READ;
               endcase
            end
            PH_DATA: begin
               wr_en  = 1'b1;
               wr_idx = ptr_q;
               ptr_d  = ptr_q + WORD_W'(WSTEP);
               cnt_d  = cnt_q - 8'd1;
               if (cnt_q == 8'd1) begin
                  phase_d = PH_CONF;
               end
            end
            PH_CONF: begin
               phase_d = PH_CMD;
               if (op == OP_CONFIRM) begin
                  status_d[7] = 1'b1;
               end else begin
                  cmd_d = OP_READ;
               end
            end
            default: begin
               phase_d = PH_CMD;
               cmd_d   = OP_READ;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= OP_READ;
         phase_q  <= PH_CMD;
         status_q <= 8'h00;
         cnt_q    <= 8'h00;
         ptr_q    <= '0;
      end else begin
         cmd_q    <= cmd_d;
         phase_q  <= phase_d;
         status_q <= status_d;
         cnt_q    <= cnt_d;
         ptr_q    <= ptr_d;
      end
   end

endmodule

// File: rtl/pflash_cmd_top.sv
module pflash_cmd_top
   import pflash_pkg::*;
#(
   parameter int WIDTH_BYTES  = 2,
   parameter int SECTOR_BYTES = 64,
   parameter int NUM_SECTORS  = 4,
   localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS,
   localparam int ADDR_W      = $clog2(TOTAL_BYTES),
   localparam int DW          = 8 * WIDTH_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata
);

   localparam int LANE_W    = $clog2(WIDTH_BYTES);
   localparam int WORDS     = TOTAL_BYTES / WIDTH_BYTES;
   localparam int WORD_W    = ADDR_W - LANE_W;
   localparam int SEC_WORDS = SECTOR_BYTES / WIDTH_BYTES;
   localparam int SECW_W    = $clog2(SEC_WORDS);
   localparam int SEC_W     = WORD_W - SECW_W;

   if (!(WIDTH_BYTES == 1 || WIDTH_BYTES == 2 || WIDTH_BYTES == 4)) begin : g_bad_width
      $error("pflash_cmd_top: WIDTH_BYTES must be 1, 2 or 4");
   end
   if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES < WIDTH_BYTES) begin : g_bad_sector
      $error("pflash_cmd_top: SECTOR_BYTES must be a power of two not below the width");
   end
   if ((NUM_SECTORS & (NUM_SECTORS - 1)) != 0 || NUM_SECTORS < 2) begin : g_bad_count
      $error("pflash_cmd_top: NUM_SECTORS must be a power of two of at least 2");
   end

   logic              bus_wr, bus_rd;
   logic [WORD_W-1:0] word_idx;
   logic [7:0]        qidx;
   logic [7:0]        qbyte;
   logic              wr_en, erase_en;
   logic [WORD_W-1:0] wr_idx;
   logic [SEC_W-1:0]  erase_sec;
   logic [DW-1:0]     arr_data;
   logic [7:0]        cmd_q;
   phase_e            phase_q;
   logic [7:0]        status_q;

   assign bus_wr   = cs && we;
   assign bus_rd   = cs && !we;
   assign word_idx = addr[ADDR_W-1:LANE_W];

   if (ADDR_W >= 8) begin : g_qidx_wide
      assign qidx = addr[7:0];
   end else begin : g_qidx_narrow
      assign qidx = 8'(addr);
   end

   pflash_ctrl #(
      .DW     (DW),
      .WORD_W (WORD_W),
      .WSTEP  (1),
      .SECW_W (SECW_W),
      .SEC_W  (SEC_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .word_idx  (word_idx),
      .wdata     (wdata),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .erase_en  (erase_en),
      .erase_sec (erase_sec),
      .cmd_q     (cmd_q),
      .phase_q   (phase_q),
      .status_q  (status_q)
   );

   pflash_array #(
      .DW     (DW),
      .WORDS  (WORDS),
      .WORD_W (WORD_W),
      .SECW_W (SECW_W),
      .SEC_W  (SEC_W)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wdata),
      .erase_en  (erase_en),
      .erase_sec (erase_sec),
      .rd_idx    (word_idx),
      .rd_data   (arr_data)
   );

   pflash_query_rom #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .NUM_SECTORS  (NUM_SECTORS)
   ) u_rom (
      .idx   (qidx),
      .qbyte (qbyte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (bus_rd) begin
         if (shows_status(cmd_q)) begin
            rdata <= DW'(status_q);
         end else if (cmd_q == OP_QUERY) begin
            rdata <= DW'(qbyte);
         end else begin
            rdata <= arr_data;
         end
      end
   end

endmodule

// File: rtl/pflash_cmd_chk.sv
module pflash_cmd_chk
   import pflash_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DW     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DW-1:0]     wdata,
   input logic [DW-1:0]     rdata,
   input logic [7:0]        cmd_q,
   input phase_e            phase_q,
   input logic [7:0]        status_q,
   input logic              wr_en,
   input logic              erase_en
);

   logic cmd_wr;
   assign cmd_wr = cs && we && (phase_q == PH_CMD);

   assert_read_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[7:0] == OP_READ) |=> (cmd_q == OP_READ && phase_q == PH_CMD));

   assert_prog_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status_q[7]);

   assert_erase_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && phase_q == PH_ARG && cmd_q == OP_ERASE && wdata[7:0] == OP_CONFIRM)
      |-> erase_en);

   assert_erase_only_on_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |-> (cs && we && wdata[7:0] == OP_CONFIRM && !wr_en));

   assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[7:0] == OP_CLEAR) |=> (status_q == 8'h00));

   assert_status_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && shows_status(cmd_q)) |=> (rdata == DW'($past(status_q))));

   assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && !we) |=> $stable(rdata));

   logic unused_ok;
   assign unused_ok = ^addr;

endmodule

bind pflash_cmd_top pflash_cmd_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .we       (we),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .cmd_q    (cmd_q),
   .phase_q  (phase_q),
   .status_q (status_q),
   .wr_en    (wr_en),
   .erase_en (erase_en)
);

// File: tb/pflash_cmd_top_tb.sv
`timescale 1ns/1ps
module pflash_cmd_top_tb;

   localparam int WB = 2;
   localparam int SB = 64;
   localparam int NS = 4;
   localparam int AW = 8;
   localparam int DW = 16;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   int     n_checks = 0;
   int     n_fails  = 0;
   item_t  sb_q[$];
   bit     done = 1'b0;

   always #2 clk = ~clk;

   pflash_cmd_top #(
      .WIDTH_BYTES  (WB),
      .SECTOR_BYTES (SB),
      .NUM_SECTORS  (NS)
   ) u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      item_t it;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
      cs = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      cs = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: a read seen at a rising edge is compared at the next falling edge
   initial begin
      forever begin
         bit fire;
         @(posedge clk);
         fire = cs && !we && rst_n;
         @(negedge clk);
         if (fire) begin
            item_t it;
            n_checks++;
            if (sb_q.size() == 0) begin
               n_fails++;
               $display("FAIL %s: read with no expected item, actual %h", "R13", rdata);
            end else begin
               it = sb_q.pop_front();
               if (rdata !== it.exp) begin
                  n_fails++;
                  $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
               end
            end
         end
      end
   end

   task automatic check_hold(input logic [DW-1:0] e);
      n_checks++;
      if (rdata !== e) begin
         n_fails++;
         $display("FAIL R13: held rdata actual %h expected %h", rdata, e);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      idle(1);
      @(negedge clk);
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(8'h00, 16'hFFFF, "R1");
      rd(8'hFE, 16'hFFFF, "R1");
      wr(8'h00, 16'h0070);
      rd(8'h00, 16'h0000, "R1");
      wr(8'h00, 16'h00FF);

      // R3 / R12 program with both opcodes, address aligned down
      wr(8'h10, 16'h0040);
      wr(8'h10, 16'hA55A);
      rd(8'h10, 16'hA55A, "R3");
      rd(8'h11, 16'hA55A, "R12");
      wr(8'h21, 16'h0010);
      wr(8'h21, 16'h1234);
      rd(8'h20, 16'h1234, "R12");

      // R8 status read and clear
      wr(8'h00, 16'h0070);
      rd(8'h00, 16'h0080, "R8");
      wr(8'h00, 16'h0050);
      rd(8'h00, 16'h0000, "R8");
      wr(8'h00, 16'h00FF);
      rd(8'h10, 16'hA55A, "R2");

      // R4 sector erase
      wr(8'h40, 16'h0040); wr(8'h40, 16'h1111);
      wr(8'h7E, 16'h0040); wr(8'h7E, 16'h2222);
      wr(8'h80, 16'h0040); wr(8'h80, 16'h3333);
      wr(8'h00, 16'h0050);
      wr(8'h55, 16'h0020);
      wr(8'h55, 16'h00D0);
      rd(8'h00, 16'h0080, "R4");
      wr(8'h00, 16'h00FF);
      rd(8'h40, 16'hFFFF, "R4");
      rd(8'h7E, 16'hFFFF, "R4");
      rd(8'h80, 16'h3333, "R4");
      rd(8'h20, 16'h1234, "R4");

      // R5 erase abort and erase error
      wr(8'h80, 16'h0020);
      wr(8'h80, 16'h00FF);
      rd(8'h80, 16'h3333, "R5");
      wr(8'h80, 16'h0020);
      wr(8'h80, 16'h0077);
      rd(8'h80, 16'h3333, "R5");

      // R6 buffered write, bus address of data writes ignored, 0xFF is data
      wr(8'h00, 16'h0050);
      wr(8'hC0, 16'h00E8);
      rd(8'h00, 16'h0080, "R6");
      wr(8'hC0, 16'h0003);
      wr(8'h00, 16'hAAAA);
      wr(8'h00, 16'h00FF);
      wr(8'h00, 16'hCCCC);
      wr(8'h00, 16'h00D0);
      rd(8'h00, 16'h0080, "R6");
      wr(8'h00, 16'h00FF);
      rd(8'hC0, 16'hAAAA, "R6");
      rd(8'hC2, 16'h00FF, "R6");
      rd(8'hC4, 16'hCCCC, "R6");
      rd(8'h00, 16'hFFFF, "R6");

      // R7 bad buffered confirm
      wr(8'hD0, 16'h00E8);
      wr(8'hD0, 16'h0001);
      wr(8'h00, 16'h5555);
      wr(8'h00, 16'h0099);
      rd(8'hD0, 16'h5555, "R7");

      // R9 query table
      wr(8'h00, 16'h0098);
      rd(8'h10, 16'h0051, "R9");
      rd(8'h11, 16'h0052, "R9");
      rd(8'h12, 16'h0059, "R9");
      rd(8'h13, 16'h0001, "R9");
      rd(8'h15, 16'h0031, "R9");
      rd(8'h27, 16'h0008, "R9");
      rd(8'h2D, 16'h0003, "R9");
      rd(8'h31, 16'h0050, "R9");
      rd(8'h3D, 16'h0000, "R9");
      rd(8'hF0, 16'h0000, "R9");
      wr(8'h00, 16'h00FF);
      rd(8'h10, 16'hA55A, "R2");

      // R10 lock/unlock without effect
      wr(8'h00, 16'h0050);
      wr(8'h40, 16'h0060);
      wr(8'h40, 16'h0001);
      rd(8'h00, 16'h0080, "R10");
      wr(8'h00, 16'h00FF);
      wr(8'h40, 16'h0040);
      wr(8'h40, 16'h4444);
      rd(8'h40, 16'h4444, "R10");
      wr(8'h00, 16'h0050);
      wr(8'h40, 16'h0060);
      wr(8'h40, 16'h00D0);
      rd(8'h00, 16'h0080, "R10");
      wr(8'h40, 16'h0060);
      wr(8'h40, 16'h0033);
      rd(8'h40, 16'h4444, "R10");

      // R11 unknown command leaves status mode
      wr(8'h00, 16'h0070);
      wr(8'h00, 16'h0033);
      rd(8'h40, 16'h4444, "R11");

      // R13 hold through idle and write cycles
      rd(8'h80, 16'h3333, "R13");
      idle(3);
      check_hold(16'h3333);
      wr(8'h00, 16'h0070);
      wr(8'h00, 16'h00FF);
      idle(1);
      check_hold(16'h3333);

      idle(4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule